// File: doc/BRIEF.md
# Quadruple-Modulus Fractional Feedback Divider

This block divides a VCO-rate clock for the feedback path of a fractional-N synthesizer. It models a prescaler with four moduli (P, P+1, P+4, P+5) cycle by cycle. A main count C sets how many prescaler cycles make one output period. Two small counts, A and B, pick which of those prescaler cycles are stretched by one and by four input cycles. The integer divide value is N = P·C + 4·B + A, with P set to 8 or 16 by a select input.

A fractional accumulator adds a 4-bit numerator once per output period, modulo 15 or 16. On each overflow, that period is lengthened by one swallowed input cycle. The average divide value is therefore N + num/M. Divide words are checked for legality and are taken only at a period boundary. An illegal set is refused and flagged, and the divider keeps running with the last legal set. A synchronous counter reset restarts counting so that it lines up with the reference.

Top module: `qm_frac_div`

## Requirements
- R1: With fraction disabled, consecutive output periods last exactly N = P·C + 4·B + A input cycles, where P = 16 when `pre_sel16` = 1 and P = 8 otherwise.
- R2: Prescaler cycle i of a period (i counted from 0) lasts P + (i<A) + 4·(i<B) input cycles, plus one in cycle 0 of a stretched period. `mode_ctl[0]` is high while i<A, `mode_ctl[1]` is high while i<B, and `mode_ctl[2]` is high during cycle 0 of a stretched period. After the first low cycle of bit 0 or bit 1 within a period, that bit stays low until the period ends.
- R3: With fraction enabled, the modulus M is 16 when `frac_mod16` = 1 and 15 otherwise. The accumulator holds a value below M. Over any M consecutive periods the input-cycle total is M·N + num, and exactly num of those periods carry the swallow flag. The first period after reset is never stretched.
- R4: With `frac_en` = 0, the numerator and modulus select are ignored: no period is stretched, `mode_ctl[2]` stays low, and num = 15 with M = 15 is legal.
- R5: A word set is legal only if C ≥ 3, C ≥ max(A,B) + 2, and not (fraction enabled, M = 15, num = 15). `cfg_err` is loaded during reset and at each period boundary with 1 for an illegal set and 0 for a legal one, and changes at no other time.
- R6: An illegal set offered at a boundary is refused, and the previous setting stays in force. An illegal set offered during reset installs the default setting C = 3, B = 0, A = 0, P = 8, integer mode (N = 24).
- R7: Input words are sampled only in the last input cycle of a period. A change made during a period leaves that period's length unchanged.
- R8: `div_pulse` is high for exactly one cycle, the cycle that follows the last input cycle of each period. The first pulse after reset is seen after N rising edges.
- R9: `rst` is synchronous. While it is high, `div_pulse` is low and all counters and the accumulator are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate input clock |
| rst | input | 1 | Synchronous counter reset, active high |
| c_word | input | 11 | Main count C (prescaler cycles per period) |
| b_word | input | 2 | Count B of prescaler cycles stretched by four |
| a_word | input | 2 | Count A of prescaler cycles stretched by one |
| frac_num | input | 4 | Fractional numerator |
| frac_mod16 | input | 1 | 1: modulus 16, 0: modulus 15 |
| pre_sel16 | input | 1 | 1: P = 16, 0: P = 8 |
| frac_en | input | 1 | Enables fractional accumulation |
| div_pulse | output | 1 | One-cycle pulse per output period |
| mode_ctl | output | 3 | Modulus control: bit0 +1, bit1 +4, bit2 swallow |
| cfg_err | output | 1 | Last offered word set was illegal |

## Verification
A table of eight word sets covers both prescaler sizes and both moduli. It includes integer settings, a zero numerator, the largest numerator for each modulus, an illegal-looking numerator with the fraction disabled, and the 32767 maximum. Each set is timed over a full modulus window. The window total separates a correct swallow count from an off-by-one accumulator. The per-cycle +1 and +4 counts in the first period show whether the A and B windows are placed correctly. Directed runs offer illegal sets during reset and in mid-run, and change words inside a period. These show whether a refused set is held, whether the default is installed, and whether a change is kept out of the period already in progress.

// File: rtl/qmd_pkg.sv
package qmd_pkg;
    localparam int CW  = 11;   // main count width
    localparam int ABW = 2;    // A and B count width
    localparam int FW  = 4;    // fraction width
    localparam int PCW = 5;    // prescaler cycle counter width

    typedef struct packed {
        logic [CW-1:0]  c;
        logic [ABW-1:0] b;
        logic [ABW-1:0] a;
        logic           p16;
        logic           fen;
        logic           m16;
        logic [FW-1:0]  num;
    } div_cfg_t;

    typedef struct packed {
        logic swallow;
        logic plus4;
        logic plus1;
    } mode_t;

    localparam div_cfg_t CFG_DEFAULT = '{c: CW'(3), b: '0, a: '0, p16: 1'b0,
                                         fen: 1'b0, m16: 1'b1, num: '0};

    function automatic logic [PCW-1:0] base_mod(input logic p16);
        return p16 ? PCW'(16) : PCW'(8);
    endfunction

    function automatic logic [FW:0] frac_mod(input logic m16);
        return m16 ? (FW+1)'(2**FW) : (FW+1)'(2**FW - 1);
    endfunction

    function automatic logic cfg_legal(input div_cfg_t k);
        logic [ABW-1:0] hi;
        hi = (k.a > k.b) ? k.a : k.b;
        return (k.c >= CW'(3)) && (k.c >= CW'(hi) + CW'(2)) &&
               !(k.fen && !k.m16 && (&k.num));
    endfunction
endpackage

// File: rtl/qmd_cfg_hold.sv
module qmd_cfg_hold
    import qmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bound,
    input  div_cfg_t cfg_in,
    output div_cfg_t cfg_q,
    output div_cfg_t cfg_nxt,
    output logic     err_q
);
    logic legal;

    always_comb begin
        legal = cfg_legal(cfg_in);
        if (legal)     cfg_nxt = cfg_in;
        else if (rst)  cfg_nxt = CFG_DEFAULT;
        else           cfg_nxt = cfg_q;
    end

    always_ff @(posedge clk) begin
        if (rst || bound) begin
            cfg_q <= cfg_nxt;
            err_q <= !legal;
        end
    end
endmodule

// File: rtl/qmd_frac_acc.sv
module qmd_frac_acc
    import qmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bound,
    input  div_cfg_t      cfg_nxt,
    output logic [FW-1:0] acc_q,
    output logic          extra_q
);
    logic [FW:0] sum;
    logic [FW:0] modv;
    logic        ovf;

    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, cfg_nxt.num};
        modv = frac_mod(cfg_nxt.m16);
        ovf  = (sum >= modv);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            // first period counts as an addition without overflow
            acc_q   <= cfg_nxt.fen ? cfg_nxt.num : '0;
            extra_q <= 1'b0;
        end else if (bound) begin
            if (!cfg_nxt.fen) begin
                acc_q   <= '0;
                extra_q <= 1'b0;
            end else begin
                acc_q   <= ovf ? FW'(sum - modv) : FW'(sum);
                extra_q <= ovf;
            end
        end
    end
endmodule

// File: rtl/qmd_mod_count.sv
module qmd_mod_count
    import qmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t cfg_q,
    input  logic     extra_q,
    output logic     bound,
    output mode_t    mode,
    output logic     pulse_q
);
    logic [CW-1:0]  idx_q;
    logic [PCW-1:0] pre_q;
    logic [PCW-1:0] len;
    logic           last_pre;
    logic           last_idx;

    always_comb begin
        mode.plus1   = (idx_q < CW'(cfg_q.a));
        mode.plus4   = (idx_q < CW'(cfg_q.b));
        mode.swallow = extra_q && (idx_q == '0);
        len = base_mod(cfg_q.p16) + PCW'(mode.plus1) + PCW'({mode.plus4, 2'b00})
              + PCW'(mode.swallow);
        last_pre = (pre_q == len - PCW'(1));
        last_idx = (idx_q == cfg_q.c - CW'(1));
        bound    = last_pre && last_idx && !rst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            idx_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= bound;
            if (last_pre) begin
                pre_q <= '0;
                idx_q <= last_idx ? '0 : idx_q + CW'(1);
            end else begin
                pre_q <= pre_q + PCW'(1);
            end
        end
    end
endmodule

// File: rtl/qm_frac_div.sv
module qm_frac_div
    import qmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] c_word,
    input  logic [ABW-1:0] b_word,
    input  logic [ABW-1:0] a_word,
    input  logic [FW-1:0] frac_num,
    input  logic          frac_mod16,
    input  logic          pre_sel16,
    input  logic          frac_en,
    output logic          div_pulse,
    output logic [2:0]    mode_ctl,
    output logic          cfg_err
);
    div_cfg_t      cfg_in;
    div_cfg_t      cfg_q;
    div_cfg_t      cfg_nxt;
    logic          prd_end;
    logic [FW-1:0] acc_q;
    logic          extra_q;
    mode_t         mode;

    always_comb begin
        cfg_in = '{c: c_word, b: b_word, a: a_word, p16: pre_sel16,
                   fen: frac_en, m16: frac_mod16, num: frac_num};
        mode_ctl = mode;
    end

    qmd_cfg_hold u_cfg (
        .clk(clk), .rst(rst), .bound(prd_end), .cfg_in(cfg_in),
        .cfg_q(cfg_q), .cfg_nxt(cfg_nxt), .err_q(cfg_err)
    );

    qmd_frac_acc u_acc (
        .clk(clk), .rst(rst), .bound(prd_end), .cfg_nxt(cfg_nxt),
        .acc_q(acc_q), .extra_q(extra_q)
    );

    qmd_mod_count u_cnt (
        .clk(clk), .rst(rst), .cfg_q(cfg_q), .extra_q(extra_q),
        .bound(prd_end), .mode(mode), .pulse_q(div_pulse)
    );
endmodule

// File: rtl/qmd_chk.sv
module qmd_chk
    import qmd_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          div_pulse,
    input logic [2:0]    mode_ctl,
    input logic          cfg_err,
    input logic          bound,
    input logic [FW-1:0] acc,
    input div_cfg_t      cfg
);
    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);
    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> !div_pulse);
    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bound |=> $stable(cfg));
    // R5
    err_boundary_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !$stable(cfg_err) |-> div_pulse);
    // R3
    acc_range_chk: assert property (@(posedge clk) disable iff (rst)
        {1'b0, acc} < frac_mod(cfg.m16));
    // R4
    no_swallow_chk: assert property (@(posedge clk) disable iff (rst)
        mode_ctl[2] |-> cfg.fen);
    // R2
    plus4_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_ctl[1] && !bound) |=> !mode_ctl[1]);
    // R2
    plus1_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_ctl[0] && !bound) |=> !mode_ctl[0]);
endmodule

bind qm_frac_div qmd_chk u_chk (
    .clk(clk), .rst(rst), .div_pulse(div_pulse), .mode_ctl(mode_ctl),
    .cfg_err(cfg_err), .bound(prd_end), .acc(acc_q), .cfg(cfg_q)
);

// File: tb/tb_qm_frac_div.sv
module tb_qm_frac_div;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [10:0] c;
        logic [1:0]  b;
        logic [1:0]  a;
        logic        p16;
        logic        fen;
        logic        m16;
        logic [3:0]  num;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{11'd3,    2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 4'd0},
        '{11'd5,    2'd3, 2'd2, 1'b1, 1'b0, 1'b1, 4'd0},
        '{11'd4,    2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 4'd5},
        '{11'd6,    2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 4'd14},
        '{11'd3,    2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 4'd15},
        '{11'd3,    2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 4'd0},
        '{11'd7,    2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 4'd15},
        '{11'd2047, 2'd3, 2'd3, 1'b1, 1'b0, 1'b1, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] c_word = 11'd3;
    logic [1:0]  b_word = '0, a_word = '0;
    logic [3:0]  frac_num = '0;
    logic        frac_mod16 = 1'b1, pre_sel16 = 1'b0, frac_en = 1'b0;
    logic        div_pulse, cfg_err;
    logic [2:0]  mode_ctl;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qm_frac_div dut (
        .clk(clk), .rst(rst), .c_word(c_word), .b_word(b_word), .a_word(a_word),
        .frac_num(frac_num), .frac_mod16(frac_mod16), .pre_sel16(pre_sel16),
        .frac_en(frac_en), .div_pulse(div_pulse), .mode_ctl(mode_ctl),
        .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int n_of(input vec_t v);
        return (v.p16 ? 16 : 8) * int'(v.c) + 4 * int'(v.b) + int'(v.a);
    endfunction

    task automatic set_words(input vec_t v);
        c_word = v.c; b_word = v.b; a_word = v.a; pre_sel16 = v.p16;
        frac_en = v.fen; frac_mod16 = v.m16; frac_num = v.num;
    endtask

    // reset with words applied; leaves bench at the negedge of period 0, cycle 0
    task automatic do_reset(input vec_t v, input bit exp_err, input string req);
        @(negedge clk);
        set_words(v);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R9", int'(div_pulse), 0);
        check(cfg_err == exp_err, req, int'(cfg_err), int'(exp_err));
        rst = 1'b0;
    endtask

    // measure one period starting at its cycle 0 (current negedge)
    task automatic run_period(output int len, output int p1, output int p4, output bit sw);
        bit done;
        sw = mode_ctl[2];
        p1 = int'(mode_ctl[0]);
        p4 = int'(mode_ctl[1]);
        len = 0;
        done = 1'b0;
        while (!done) begin
            @(negedge clk);
            len++;
            if (div_pulse) done = 1'b1;
            else begin
                p1 += int'(mode_ctl[0]);
                p4 += int'(mode_ctl[1]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int len, p1, p4, total, nsw, win, n, pp, e1, e4, exp_tot;
        bit sw;
        vec_t v;

        // table walk: R1, R2, R3, R4, R8
        for (int k = 0; k < NV; k++) begin
            v = VECS[k];
            n = n_of(v);
            pp = v.p16 ? 16 : 8;
            do_reset(v, 1'b0, "R5");
            win = v.fen ? (v.m16 ? 16 : 15) : 2;
            total = 0; nsw = 0;
            for (int w = 0; w < win; w++) begin
                run_period(len, p1, p4, sw);
                if (w == 0) begin
                    e1 = 0; e4 = 0;
                    for (int i = 0; i < int'(v.a); i++) e1 += pp + 1 + ((i < int'(v.b)) ? 4 : 0);
                    for (int i = 0; i < int'(v.b); i++) e4 += pp + 4 + ((i < int'(v.a)) ? 1 : 0);
                    check(len == n, "R8", len, n);
                    check(sw == 1'b0, "R3", int'(sw), 0);
                    check(p1 == e1, "R2", p1, e1);
                    check(p4 == e4, "R2", p4, e4);
                end
                total += len;
                nsw += int'(sw);
            end
            exp_tot = win * n + (v.fen ? int'(v.num) : 0);
            check(total == exp_tot, v.fen ? "R3" : "R1", total, exp_tot);
            check(nsw == (v.fen ? int'(v.num) : 0), v.fen ? "R3" : "R4", nsw,
                  v.fen ? int'(v.num) : 0);
        end

        // R6: illegal C at reset installs default N = 24
        v = '{11'd2, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 4'd0};
        do_reset(v, 1'b1, "R5");
        run_period(len, p1, p4, sw);
        check(len == 24, "R6", len, 24);

        // R5: numerator 15 with modulus 15 refused
        v = '{11'd4, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 4'd15};
        do_reset(v, 1'b1, "R5");
        run_period(len, p1, p4, sw);
        check(len == 24, "R6", len, 24);

        // R4: same words legal with fraction off, N = 64
        v.fen = 1'b0;
        do_reset(v, 1'b0, "R4");
        run_period(len, p1, p4, sw);
        check(len == 64, "R4", len, 64);
        run_period(len, p1, p4, sw);
        check(len == 64 && !sw, "R4", len, 64);

        // R7 / R6: mid-run changes
        v = VECS[0];                       // N = 29
        do_reset(v, 1'b0, "R5");
        run_period(len, p1, p4, sw);
        check(len == 29, "R1", len, 29);
        v = '{11'd3, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 4'd0};   // C < B+2: illegal
        set_words(v);
        run_period(len, p1, p4, sw);
        check(len == 29, "R7", len, 29);
        check(cfg_err == 1'b1, "R5", int'(cfg_err), 1);
        run_period(len, p1, p4, sw);
        check(len == 29, "R6", len, 29);
        v = '{11'd4, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 4'd0};   // N = 32
        set_words(v);
        run_period(len, p1, p4, sw);
        check(len == 29, "R7", len, 29);
        check(cfg_err == 1'b0, "R5", int'(cfg_err), 0);
        run_period(len, p1, p4, sw);
        check(len == 32, "R7", len, 32);

        // R9: reset in mid-period restarts the count
        repeat (5) @(negedge clk);
        do_reset(v, 1'b0, "R9");
        run_period(len, p1, p4, sw);
        check(len == 32, "R9", len, 32);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule